// File: doc/BRIEF.md
# Block Port Transfer Engine

This unit moves bytes between memory and a 16-bit I/O port space on behalf of an 8-bit processor core. The core supplies a start strobe, an operation selection (direction, address step direction, single or repeating) and the current values of the byte counter B, the port low byte C and the 16-bit memory pointer HL. The engine performs one transfer per iteration. An inbound transfer reads a port and writes the byte to memory. An outbound transfer reads memory and writes the byte to a port. After each iteration the engine reports the updated counter, pointer and flag byte, along with the number of machine cycles that iteration accounts for.

Both buses use a request/acknowledge handshake. Only one request is active at a time. It holds its address, direction and write data until the acknowledge arrives. The repeating form loops until the counter reaches zero. A repeating operation started with a zero counter wraps to 0xFF first and so performs 256 iterations.

Top module: `bio_xfer_unit`

## Requirements
- R1: An inbound iteration first requests a port read at address {B, C}. It then requests a memory write of the returned byte at address HL.
- R2: An outbound iteration first requests a memory read at HL. It then requests a port write of that byte at address {B-1, C}, with C in the low byte.
- R3: Each iteration decrements B by one modulo 256, so 0x00 becomes 0xFF. It moves HL by +1 when op_down is 0 and by -1 when op_down is 1, modulo 65536.
- R4: In f_out, bit 7 equals bit 7 of the new B. Bit 6 is 1 when the new B is zero. Bits 5 and 3 equal the same bits of the new B. Bit 1 equals bit 7 of the transferred byte.
- R5: A 9-bit sum k adds the transferred byte to an addend. The addend is C+1 for inbound with op_down=0, C-1 for inbound with op_down=1, and the low byte of the updated HL for outbound. f_out bits 4 and 0 are both 1 exactly when k exceeds 255.
- R6: f_out bit 2 is 1 when the 8-bit value (k mod 8) XOR new B has an even number of one bits.
- R7: With op_repeat=0 exactly one iteration runs. With op_repeat=1 iterations continue while the new B is non-zero. done pulses together with the step pulse of the last iteration.
- R8: Each iteration produces a one-cycle step_valid pulse. On that pulse step_cycles is 21 when another iteration follows and 16 for the last one.
- R9: At most one of mem_req and io_req is high in any cycle. A request that has not been acknowledged stays high with unchanged address and direction.
- R10: A start pulse that arrives while an operation is running is ignored. It does not change the running operation's accesses or results.
- R11: After reset no request is active, step_valid and done are low, and b_out, hl_out and f_out are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op_to_port | input | 1 | 1 = memory to port, 0 = port to memory |
| op_down | input | 1 | 1 = HL decrements, 0 = HL increments |
| op_repeat | input | 1 | 1 = loop until B reaches zero |
| b_in | input | 8 | Starting counter / port high byte |
| c_in | input | 8 | Port low byte |
| hl_in | input | 16 | Starting memory pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |
| io_req | output | 1 | Port access request |
| io_we | output | 1 | Port access is a write |
| io_addr | output | 16 | Port address |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data, valid with io_ack |
| io_ack | input | 1 | Port access complete |
| b_out | output | 8 | Counter after the latest iteration |
| hl_out | output | 16 | Pointer after the latest iteration |
| f_out | output | 8 | Flags from the latest iteration |
| step_cycles | output | 5 | Cycle cost of the latest iteration |
| step_valid | output | 1 | One-cycle pulse per finished iteration |
| done | output | 1 | One-cycle pulse when the operation ends |

## Verification
The bench sets C to 0xFF and to 0x00 so that the C+1 and C-1 addends wrap. A design that used the wrong neighbour of C would produce the wrong H, C and P/V flags. It runs outbound transfers and checks that the port address carries the already decremented B and that the addend is the low byte of the updated HL. A design that used the old values would show a wrong io_addr or a wrong carry. It starts a repeat with B at zero and expects 256 iterations. A design that tested B before decrementing would stop after one iteration. It also steps HL across 0xFFFF and 0x0000, varies the acknowledge latency, and injects a start pulse in the middle of an operation. A design that re-latched its operands would then show a diverging access stream.

// File: rtl/bio_pkg.sv
// Shared types for the block port transfer engine.
// Assumes an 8-bit data path and a 16-bit address formed from two bytes.
package bio_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    // Bit positions inside the flag byte
    localparam int FL_SIGN  = 7;
    localparam int FL_ZERO  = 6;
    localparam int FL_B5    = 5;
    localparam int FL_HALF  = 4;
    localparam int FL_B3    = 3;
    localparam int FL_PAR   = 2;
    localparam int FL_NEG   = 1;
    localparam int FL_CARRY = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IN_PORT,
        ST_IN_MEM,
        ST_OUT_MEM,
        ST_OUT_PORT
    } bio_state_e;

    typedef struct packed {
        logic to_port;
        logic down;
        logic again;
    } bio_op_t;

endpackage

// File: rtl/bio_flag_calc.sv
// Flag generator for one transfer iteration.
// Purely combinational; assumes the caller selects the addend per direction.
module bio_flag_calc
    import bio_pkg::*;
(
    input  logic [BYTE_W-1:0] xfer_byte,
    input  logic [BYTE_W-1:0] new_b,
    input  logic [BYTE_W-1:0] addend,
    output logic [BYTE_W-1:0] flags
);

    logic       k_over;
    logic [2:0] k_low;

    // Carry out of the byte sum and its three low bits
    always_comb begin
        k_over = ({1'b0, xfer_byte} + {1'b0, addend}) > 9'd255;
        k_low  = xfer_byte[2:0] + addend[2:0];
    end

    // Assemble the flag byte
    always_comb begin
        flags           = '0;
        flags[FL_SIGN]  = new_b[7];
        flags[FL_ZERO]  = (new_b == '0);
        flags[FL_B5]    = new_b[5];
        flags[FL_HALF]  = k_over;
        flags[FL_B3]    = new_b[3];
        flags[FL_PAR]   = ~^({5'b0, k_low} ^ new_b);
        flags[FL_NEG]   = xfer_byte[7];
        flags[FL_CARRY] = k_over;
    end

endmodule

// File: rtl/bio_seq.sv
// Iteration sequencer: latches operands on start, runs the two handshaked
// accesses of each iteration, then updates counter, pointer and flags.
// Assumes acknowledges are single-cycle pulses answering a held request.
module bio_seq
    import bio_pkg::*;
#(
    parameter int CYC_MORE = 21,
    parameter int CYC_LAST = 16,
    parameter int CNT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  bio_op_t           op_i,
    input  logic [BYTE_W-1:0] b_in,
    input  logic [BYTE_W-1:0] c_in,
    input  logic [ADDR_W-1:0] hl_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              io_req,
    output logic              io_we,
    output logic [ADDR_W-1:0] io_addr,
    output logic [BYTE_W-1:0] io_wdata,
    input  logic [BYTE_W-1:0] io_rdata,
    input  logic              io_ack,
    output logic [BYTE_W-1:0] calc_byte,
    output logic [BYTE_W-1:0] calc_new_b,
    output logic [BYTE_W-1:0] calc_addend,
    input  logic [BYTE_W-1:0] calc_flags,
    output logic [BYTE_W-1:0] b_q,
    output logic [ADDR_W-1:0] hl_q,
    output logic [BYTE_W-1:0] f_q,
    output logic [CNT_W-1:0]  step_cycles,
    output logic              step_valid,
    output logic              done
);

    bio_state_e        state;
    bio_op_t           op_q;
    logic [BYTE_W-1:0] c_q;
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] nb;
    logic [ADDR_W-1:0] nhl;
    logic              last;
    logic              fin;

    // Next counter, pointer and loop decision for the running iteration
    always_comb begin
        nb   = b_q - 1'b1;
        nhl  = op_q.down ? hl_q - 1'b1 : hl_q + 1'b1;
        last = !(op_q.again && (nb != '0));
        fin  = ((state == ST_IN_MEM) && mem_ack) || ((state == ST_OUT_PORT) && io_ack);
    end

    // Operands handed to the flag generator
    always_comb begin
        calc_byte   = byte_q;
        calc_new_b  = nb;
        calc_addend = op_q.to_port ? nhl[BYTE_W-1:0]
                    : (op_q.down ? c_q - 1'b1 : c_q + 1'b1);
    end

    // Bus requests decoded from the state
    always_comb begin
        mem_req   = (state == ST_IN_MEM) || (state == ST_OUT_MEM);
        mem_we    = (state == ST_IN_MEM);
        mem_addr  = hl_q;
        mem_wdata = byte_q;
        io_req    = (state == ST_IN_PORT) || (state == ST_OUT_PORT);
        io_we     = (state == ST_OUT_PORT);
        io_addr   = (state == ST_OUT_PORT) ? {nb, c_q} : {b_q, c_q};
        io_wdata  = byte_q;
    end

    // State machine and architectural result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            op_q        <= '0;
            c_q         <= '0;
            byte_q      <= '0;
            b_q         <= '0;
            hl_q        <= '0;
            f_q         <= '0;
            step_cycles <= '0;
            step_valid  <= 1'b0;
            done        <= 1'b0;
        end else begin
            step_valid <= 1'b0;
            done       <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q  <= op_i;
                        b_q   <= b_in;
                        c_q   <= c_in;
                        hl_q  <= hl_in;
                        state <= op_i.to_port ? ST_OUT_MEM : ST_IN_PORT;
                    end
                end
                ST_IN_PORT: begin
                    if (io_ack) begin
                        byte_q <= io_rdata;
                        state  <= ST_IN_MEM;
                    end
                end
                ST_OUT_MEM: begin
                    if (mem_ack) begin
                        byte_q <= mem_rdata;
                        state  <= ST_OUT_PORT;
                    end
                end
                ST_IN_MEM, ST_OUT_PORT: begin
                    if (fin) begin
                        b_q         <= nb;
                        hl_q        <= nhl;
                        f_q         <= calc_flags;
                        step_valid  <= 1'b1;
                        step_cycles <= last ? CNT_W'(CYC_LAST) : CNT_W'(CYC_MORE);
                        done        <= last;
                        if (last)
                            state <= ST_IDLE;
                        else
                            state <= op_q.to_port ? ST_OUT_MEM : ST_IN_PORT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ONE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && io_req)); // R9
    AST_IO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && !io_ack |=> io_req && $stable(io_addr) && $stable(io_we)); // R9
    AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9
    AST_B_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> b_q == $past(b_q) - 8'd1); // R3
    AST_LAST_COST: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid && done |-> step_cycles == CNT_W'(CYC_LAST)); // R8
    AST_MORE_COST: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid && !done |-> step_cycles == CNT_W'(CYC_MORE) && b_q != '0); // R7
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IDLE |=> $stable(op_q) && $stable(c_q)); // R10

endmodule

// File: rtl/bio_xfer_unit.sv
// Block port transfer engine top: joins the sequencer and the flag
// generator. Assumes the surrounding core holds operands only at start.
module bio_xfer_unit #(
    parameter int CYC_MORE = 21,
    parameter int CYC_LAST = 16,
    parameter int CNT_W    = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        op_to_port,
    input  logic        op_down,
    input  logic        op_repeat,
    input  logic [7:0]  b_in,
    input  logic [7:0]  c_in,
    input  logic [15:0] hl_in,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    input  logic        mem_ack,
    output logic        io_req,
    output logic        io_we,
    output logic [15:0] io_addr,
    output logic [7:0]  io_wdata,
    input  logic [7:0]  io_rdata,
    input  logic        io_ack,
    output logic [7:0]  b_out,
    output logic [15:0] hl_out,
    output logic [7:0]  f_out,
    output logic [CNT_W-1:0] step_cycles,
    output logic        step_valid,
    output logic        done
);

    bio_pkg::bio_op_t op_sel;
    logic [7:0]       calc_byte;
    logic [7:0]       calc_new_b;
    logic [7:0]       calc_addend;
    logic [7:0]       calc_flags;

    // Pack the operation selection
    always_comb begin
        op_sel.to_port = op_to_port;
        op_sel.down    = op_down;
        op_sel.again   = op_repeat;
    end

    bio_seq #(
        .CYC_MORE (CYC_MORE),
        .CYC_LAST (CYC_LAST),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op_i        (op_sel),
        .b_in        (b_in),
        .c_in        (c_in),
        .hl_in       (hl_in),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ack     (mem_ack),
        .io_req      (io_req),
        .io_we       (io_we),
        .io_addr     (io_addr),
        .io_wdata    (io_wdata),
        .io_rdata    (io_rdata),
        .io_ack      (io_ack),
        .calc_byte   (calc_byte),
        .calc_new_b  (calc_new_b),
        .calc_addend (calc_addend),
        .calc_flags  (calc_flags),
        .b_q         (b_out),
        .hl_q        (hl_out),
        .f_q         (f_out),
        .step_cycles (step_cycles),
        .step_valid  (step_valid),
        .done        (done)
    );

    bio_flag_calc u_flags (
        .xfer_byte (calc_byte),
        .new_b     (calc_new_b),
        .addend    (calc_addend),
        .flags     (calc_flags)
    );

endmodule

// File: tb/test_bio_xfer_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task predicts every access and every
// iteration result; bus responders and a step monitor pop and compare.
module test_bio_xfer_unit;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, start, op_to_port, op_down, op_repeat;
    logic [7:0]  b_in, c_in;
    logic [15:0] hl_in;
    logic        mem_req, mem_we, mem_ack, io_req, io_we, io_ack;
    logic [15:0] mem_addr, io_addr, hl_out;
    logic [7:0]  mem_wdata, mem_rdata, io_wdata, io_rdata, b_out, f_out;
    logic [4:0]  step_cycles;
    logic        step_valid, done;

    bio_xfer_unit i_bio_xfer_unit (.*);

    typedef struct {logic [7:0] b; logic [15:0] hl; logic [7:0] f; int cyc; logic last;} step_t;
    typedef struct {logic is_io; logic we; logic [15:0] addr; logic [7:0] data; string tag;} acc_t;

    step_t step_q[$];
    acc_t  acc_q[$];
    int total = 0, bad = 0, lat = 0, mem_wait = 0, io_wait = 0, overlap = 0;

    function automatic logic [7:0] io_fn(logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h6B;
    endfunction
    function automatic logic [7:0] mem_fn(logic [15:0] a);
        return (a[7:0] + {a[14:8], a[15]}) ^ 8'hD2;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_acc(logic is_io, logic we, logic [15:0] addr, logic [7:0] data);
        acc_t e;
        if (acc_q.size() == 0) begin
            check("R1", "unexpected access", 1, 0);
            return;
        end
        e = acc_q.pop_front();
        check(e.tag, "access bus", is_io, e.is_io);
        check(e.tag, "access direction", we, e.we);
        check(e.tag, "access address", addr, e.addr);
        if (e.we) check(e.tag, "write data", data, e.data);
    endtask

    // Memory responder: acknowledges after lat idle cycles
    always @(negedge clk) begin
        if (mem_req && io_req) overlap <= overlap + 1;
        mem_ack <= 1'b0;
        if (rst_n && mem_req && !mem_ack) begin
            if (mem_wait >= lat) begin
                mem_ack   <= 1'b1;
                mem_wait  <= 0;
                mem_rdata <= mem_fn(mem_addr);
                check_acc(1'b0, mem_we, mem_addr, mem_wdata);
            end else mem_wait <= mem_wait + 1;
        end
    end

    // Port responder
    always @(negedge clk) begin
        io_ack <= 1'b0;
        if (rst_n && io_req && !io_ack) begin
            if (io_wait >= lat) begin
                io_ack   <= 1'b1;
                io_wait  <= 0;
                io_rdata <= io_fn(io_addr);
                check_acc(1'b1, io_we, io_addr, io_wdata);
            end else io_wait <= io_wait + 1;
        end
    end

    // Step monitor
    always @(negedge clk) begin
        if (rst_n && step_valid) begin
            if (step_q.size() == 0) check("R7", "extra iteration", 1, 0);
            else begin
                step_t e;
                e = step_q.pop_front();
                check("R3", "counter", b_out, e.b);
                check("R3", "pointer", hl_out, e.hl);
                check("R4", "flags S/Z/5/3/N", f_out & 8'hEA, e.f & 8'hEA);
                check("R5", "flags H/C", f_out & 8'h11, e.f & 8'h11);
                check("R6", "flag P/V", f_out & 8'h04, e.f & 8'h04);
                check("R8", "cycle cost", step_cycles, e.cyc);
                check("R7", "done with last", done, e.last);
            end
        end
    end

    task automatic run_op(bit to_port, bit down, bit again, logic [7:0] b, logic [7:0] c,
                          logic [15:0] hl, bit stray);
        logic [7:0]  cb = b;
        logic [15:0] chl = hl;
        bit more;
        do begin
            logic [7:0]  byt, nb, add;
            logic [15:0] nhl;
            logic [8:0]  k;
            step_t s;
            nb  = cb - 8'd1;
            nhl = down ? chl - 16'd1 : chl + 16'd1;
            if (!to_port) begin
                byt = io_fn({cb, c});
                acc_q.push_back('{1'b1, 1'b0, {cb, c}, 8'h00, "R1"});
                acc_q.push_back('{1'b0, 1'b1, chl, byt, "R1"});
                add = down ? c - 8'd1 : c + 8'd1;
            end else begin
                byt = mem_fn(chl);
                acc_q.push_back('{1'b0, 1'b0, chl, 8'h00, "R2"});
                acc_q.push_back('{1'b1, 1'b1, {nb, c}, byt, "R2"});
                add = nhl[7:0];
            end
            k    = {1'b0, byt} + {1'b0, add};
            more = again && (nb != 8'd0);
            s.b  = nb;
            s.hl = nhl;
            s.f  = {nb[7], nb == 8'd0, nb[5], k[8], nb[3], ~^({5'b0, k[2:0]} ^ nb), byt[7], k[8]};
            s.cyc  = more ? 21 : 16;
            s.last = !more;
            step_q.push_back(s);
            cb = nb;
            chl = nhl;
        end while (more);

        @(negedge clk);
        start = 1'b1; op_to_port = to_port; op_down = down; op_repeat = again;
        b_in = b; c_in = c; hl_in = hl;
        @(negedge clk);
        start = 1'b0;
        if (stray) begin
            // R10: start pulse with different operands while running
            repeat (4) @(negedge clk);
            start = 1'b1; op_to_port = ~to_port; op_down = ~down; op_repeat = 1'b0;
            b_in = 8'h33; c_in = 8'h44; hl_in = 16'h5555;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        check("R7", "iterations left", step_q.size(), 0);
        check(stray ? "R10" : "R1", "accesses left", acc_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; op_to_port = 1'b0; op_down = 1'b0; op_repeat = 1'b0;
        b_in = '0; c_in = '0; hl_in = '0;
        mem_ack = 1'b0; io_ack = 1'b0; mem_rdata = '0; io_rdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "mem_req", mem_req, 0);
        check("R11", "io_req", io_req, 0);
        check("R11", "step/done", {step_valid, done}, 0);
        check("R11", "results", {b_out, hl_out, f_out}, 0);

        lat = 0; run_op(0, 0, 0, 8'h05, 8'hFF, 16'h1234, 0);      // R1 C+1 wraps
        lat = 1; run_op(0, 1, 0, 8'h01, 8'h00, 16'h0000, 0);      // R1 C-1 wraps, HL wraps
        lat = 2; run_op(1, 0, 0, 8'h80, 8'h3C, 16'hFFFF, 0);      // R2 HL wraps to 0
        lat = 0; run_op(1, 1, 0, 8'h21, 8'h9A, 16'h40F0, 0);      // R2
        lat = 1; run_op(0, 0, 1, 8'h06, 8'h7E, 16'h2000, 1);      // R7 R10
        lat = 3; run_op(1, 1, 1, 8'h05, 8'h10, 16'h8003, 0);      // R7 R8
        lat = 0; run_op(1, 0, 1, 8'h01, 8'hC8, 16'h00FE, 0);      // R7 single iteration
        lat = 0; run_op(0, 1, 1, 8'h00, 8'h55, 16'h0100, 0);      // R7 256 iterations
        lat = 1; run_op(1, 0, 1, 8'h00, 8'hE1, 16'hFF80, 0);      // R7 256 iterations
        check("R9", "overlapping requests", overlap, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule